// File: doc/BRIEF.md
# Shared External Interrupt Pending Grouper

This block gathers twenty external interrupt lines into one secondary pending register and folds them onto two shared primary request lines. Lines 4 to 7 drive one shared request and lines 8 to 23 drive the other. The primary controller sees only the shared bit. Software then reads the secondary register to find which individual lines fired. A per-line mask lets software hold a line back from its shared request without losing its pending record. Lines 0 to 3 are not recorded here. They pass straight through to their own dedicated primary requests.

The inputs are single-cycle request pulses that have already been synchronized. A small register port selects either the pending register or the mask register. Writes to the pending register are write-1-to-clear. Writes to the mask register load it. Read data is combinational from the selected register.

Top module: `eint_grouper`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads 0xFFFFF0 (every shared line masked), and both shared requests are low.
- R2: A pulse on line n (4 to 23) sets pending bit n at the next clock edge, and the bit stays set until software clears it.
- R3: Bits 0 to 3 of both the pending register and the mask register always read 0. Writes to those bits are ignored, and pulses on lines 0 to 3 set no pending bit.
- R4: Lines 0 to 3 appear on directReq[3:0] in the same cycle, with no register in the path.
- R5: Several pending bits can be set at the same time, and each keeps its own state.
- R6: A write with regSel=0 clears every pending bit where regWrData holds 1 and leaves every other bit unchanged.
- R7: A write with regSel=1 loads bits 4 to 23 of the mask register from regWrData. A mask bit of 1 means masked.
- R8: A masked line still sets its pending bit but does not drive its shared request.
- R9: sharedLoReq is high exactly while any of bits 4 to 7 is both pending and unmasked.
- R10: sharedHiReq is high exactly while any of bits 8 to 23 is both pending and unmasked.
- R11: When a request pulse and a write-1 clear hit the same line in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lineReq | input | 24 | Synchronized request pulses, one per external line |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 selects pending, 1 selects mask |
| regWrData | input | 24 | Register write data |
| regRdData | output | 24 | Read data from the selected register |
| directReq | output | 4 | Pass-through requests for lines 0 to 3 |
| sharedLoReq | output | 1 | Shared primary request for lines 4 to 7 |
| sharedHiReq | output | 1 | Shared primary request for lines 8 to 23 |

## Verification
The bench drives a request and a clear onto the same line in one cycle. A design where the clear wins would read the bit back as 0 and lose an interrupt. It clears one of two pending bits in the high group and checks that the shared request stays high. A design that dropped the shared line on any clear would then miss the remaining source. It masks a pending line and checks that the bit still reads as set while its shared request falls. Finally, it writes ones into the reserved low bits of both registers and pulses lines 0 to 3. A design that stored those bits would read back nonzero.

// File: rtl/eint_pkg.sv
package eint_pkg;
  // Strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic pendClr;   // write-1-to-clear into pending register
    logic maskLoad;  // load mask register
    logic rdMask;    // read mux selects mask register
  } eintStrobes_t;
endpackage

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
(
  input  logic         regWrEn,
  input  logic         regSel,
  output eintStrobes_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.pendClr  = regWrEn && !regSel;
    strobes.maskLoad = regWrEn && regSel;
    strobes.rdMask   = regSel;
  end
endmodule

// File: rtl/eint_group_or.sv
module eint_group_or #(
  parameter int WIDTH = 24,
  parameter int LO    = 4,
  parameter int HI    = 7
) (
  input  logic [WIDTH-1:0] vec,
  output logic             anySet
);
  always_comb begin
    anySet = 1'b0;
    for (int i = LO; i <= HI; i++) anySet = anySet | vec[i];
  end
endmodule

// File: rtl/eint_dpath.sv
module eint_dpath
  import eint_pkg::*;
#(
  parameter int NUM_LINES    = 24,
  parameter int DIRECT_LINES = 4,
  parameter int SPLIT_LINE   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lineReq,
  input  logic [NUM_LINES-1:0] wrData,
  input  eintStrobes_t         strobes,
  output logic [NUM_LINES-1:0] rdData,
  output logic                 sharedLo,
  output logic                 sharedHi
);
  localparam logic [NUM_LINES-1:0] SHARED_BITS = ~((NUM_LINES)'((1 << DIRECT_LINES) - 1));

  logic [NUM_LINES-1:0] pendQ, pendD;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] eligible;

  // Set has priority over clear; reserved low bits never store
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (i < DIRECT_LINES) pendD[i] = 1'b0;
      else pendD[i] = (pendQ[i] & ~(strobes.pendClr & wrData[i])) | lineReq[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendQ <= '0;
    else        pendQ <= pendD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                maskQ <= SHARED_BITS;
    else if (strobes.maskLoad) maskQ <= wrData & SHARED_BITS;
  end

  assign rdData   = strobes.rdMask ? maskQ : pendQ;
  assign eligible = pendQ & ~maskQ;

  eint_group_or #(.WIDTH(NUM_LINES), .LO(DIRECT_LINES), .HI(SPLIT_LINE-1)) uLoOr (
    .vec(eligible), .anySet(sharedLo)
  );
  eint_group_or #(.WIDTH(NUM_LINES), .LO(SPLIT_LINE), .HI(NUM_LINES-1)) uHiOr (
    .vec(eligible), .anySet(sharedHi)
  );

  // R2
  req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lineReq) & SHARED_BITS & ~pendQ) == '0));

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pendClr |=> (($past(wrData) & ~$past(lineReq) & pendQ) == '0));

  // R9
  lo_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sharedLo && !strobes.pendClr && !strobes.maskLoad) |=> sharedLo);

  // R10
  hi_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sharedHi && !strobes.pendClr && !strobes.maskLoad) |=> sharedHi);
endmodule

// File: rtl/eint_grouper.sv
module eint_grouper
  import eint_pkg::*;
#(
  parameter int NUM_LINES    = 24,
  parameter int DIRECT_LINES = 4,
  parameter int SPLIT_LINE   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_LINES-1:0]    lineReq,
  input  logic                    regWrEn,
  input  logic                    regSel,
  input  logic [NUM_LINES-1:0]    regWrData,
  output logic [NUM_LINES-1:0]    regRdData,
  output logic [DIRECT_LINES-1:0] directReq,
  output logic                    sharedLoReq,
  output logic                    sharedHiReq
);
  eintStrobes_t strobes;

  eint_ctrl uCtrl (
    .regWrEn(regWrEn), .regSel(regSel), .strobes(strobes)
  );

  eint_dpath #(
    .NUM_LINES(NUM_LINES), .DIRECT_LINES(DIRECT_LINES), .SPLIT_LINE(SPLIT_LINE)
  ) uDpath (
    .clk(clk), .rst_n(rst_n), .lineReq(lineReq), .wrData(regWrData),
    .strobes(strobes), .rdData(regRdData),
    .sharedLo(sharedLoReq), .sharedHi(sharedHiReq)
  );

  // R4: dedicated lines bypass the register
  assign directReq = lineReq[DIRECT_LINES-1:0];
endmodule

// File: tb/eint_grouper_test.sv
module eint_grouper_test;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] lineReq = '0;
  logic        regWrEn = 0;
  logic        regSel = 0;
  logic [23:0] regWrData = '0;
  logic [23:0] regRdData;
  logic [3:0]  directReq;
  logic        sharedLoReq, sharedHiReq;

  int checks = 0;
  int fails = 0;

  eint_grouper uut (
    .clk(clk), .rst_n(rst_n), .lineReq(lineReq), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .directReq(directReq), .sharedLoReq(sharedLoReq), .sharedHiReq(sharedHiReq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [23:0] data);
    @(negedge clk);
    regSel = sel; regWrData = data; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0; regWrData = '0;
  endtask

  task automatic regRead(input logic sel, output logic [23:0] data);
    @(negedge clk);
    regSel = sel;
    #1 data = regRdData;
  endtask

  task automatic pulse(input logic [23:0] v);
    @(negedge clk);
    lineReq = v;
    @(negedge clk);
    lineReq = '0;
  endtask

  task automatic testReset;
    logic [23:0] d;
    regRead(0, d); check("R1 pending after reset", d, 24'h0);
    regRead(1, d); check("R1 mask after reset", d, 24'hFFFFF0);
    check("R1 shared outputs after reset", {22'd0, sharedHiReq, sharedLoReq}, 24'h0);
  endtask

  task automatic testDirect;
    logic [23:0] d;
    @(negedge clk);
    lineReq = 24'h00000A;
    #1 check("R4 direct pass-through", {20'd0, directReq}, 24'h00000A);
    @(negedge clk);
    lineReq = 24'h00000F;
    #1 check("R4 direct pass-through all", {20'd0, directReq}, 24'h00000F);
    @(negedge clk);
    lineReq = '0;
    regRead(0, d); check("R3 low lines not recorded", d, 24'h0);
    regWrite(1, 24'h00000F);
    regRead(1, d); check("R3 mask low bits read 0", d, 24'h0);
    regWrite(1, 24'h000000);
    regRead(1, d); check("R7 mask cleared", d, 24'h0);
  endtask

  task automatic testSetAndGroups;
    logic [23:0] d;
    pulse(24'h000020);
    regRead(0, d); check("R2 line5 pending", d, 24'h000020);
    check("R9 lo asserted by line5", {23'd0, sharedLoReq}, 24'h1);
    check("R10 hi idle with only line5", {23'd0, sharedHiReq}, 24'h0);
    repeat (3) @(negedge clk);
    check("R2 line5 stays pending", {23'd0, sharedLoReq}, 24'h1);
    pulse(24'h800200);
    regRead(0, d); check("R5 several pending", d, 24'h800220);
    check("R10 hi asserted", {23'd0, sharedHiReq}, 24'h1);
  endtask

  task automatic testClear;
    logic [23:0] d;
    regWrite(0, 24'h000200);
    regRead(0, d); check("R6 clear one bit", d, 24'h800020);
    check("R10 hi held by line23", {23'd0, sharedHiReq}, 24'h1);
    regWrite(0, 24'h80002F);
    regRead(0, d); check("R6 clear rest", d, 24'h0);
    check("R9 R10 both low after clear", {22'd0, sharedHiReq, sharedLoReq}, 24'h0);
    pulse(24'h000040);
    regWrite(0, 24'h000000);
    regRead(0, d); check("R6 zero write keeps bit", d, 24'h000040);
  endtask

  task automatic testMask;
    logic [23:0] d;
    regWrite(1, 24'h000040);
    check("R8 masked line drops lo", {23'd0, sharedLoReq}, 24'h0);
    regRead(0, d); check("R8 masked bit still pending", d, 24'h000040);
    regWrite(1, 24'h001040);
    pulse(24'h001000);
    regRead(0, d); check("R8 masked line12 sets pending", d, 24'h001040);
    check("R8 masked line12 no hi", {23'd0, sharedHiReq}, 24'h0);
    regWrite(1, 24'h000000);
    check("R7 R10 unmask raises hi", {22'd0, sharedHiReq, sharedLoReq}, 24'h3);
    regWrite(0, 24'hFFFFFF);
    regRead(0, d); check("R6 all cleared", d, 24'h0);
  endtask

  task automatic testCollide;
    logic [23:0] d;
    pulse(24'h000400);
    @(negedge clk);
    lineReq = 24'h000400; regSel = 0; regWrData = 24'h000400; regWrEn = 1;
    @(negedge clk);
    lineReq = '0; regWrEn = 0; regWrData = '0;
    regRead(0, d); check("R11 set wins over clear", d, 24'h000400);
    @(negedge clk);
    lineReq = 24'h000800; regSel = 0; regWrData = 24'h000400; regWrEn = 1;
    @(negedge clk);
    lineReq = '0; regWrEn = 0; regWrData = '0;
    regRead(0, d); check("R11 other line cleared while new line sets", d, 24'h000800);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    testReset();
    testDirect();
    testSetAndGroups();
    testClear();
    testMask();
    testCollide();
    report();
  end
endmodule